// File: doc/BRIEF.md
# General-Purpose Parallel Capture Port

This block connects a chip to an external parallel converter or video device through a half-duplex port. The port has its own externally supplied clock, three frame-sync lines and a data bus of up to 16 bits. A two-bit mode selects one of three roles. In the first, the block is a sync slave: it watches an incoming frame sync and samples data. In the second, it drives horizontal and vertical syncs and samples data. In the third, it drives both syncs and data.

Every transfer is framed as a window. A window begins at a line start, meaning an incoming sync edge or the start of a generated line. The block then waits a programmed number of port-clock edges and moves a programmed number of words, one per port-clock edge. Received words reach the system clock domain through a small asynchronous FIFO and leave it as a valid/ready stream. Words to transmit enter the same way through a second FIFO.

Configuration inputs are quasi-static. They may change only while the enable input is low. The port clock must run at no more than half the system clock rate.

Top module: `par_sync_port`

## Requirements
- R1: In receive-slave mode (`cfg_mode` = 00), a window opens at a port-clock rising edge that samples `fs_in[0]` high after sampling it low at the previous edge. Sync edges that arrive while a window is open are ignored.
- R2: After a line start, the first word moves at the port-clock edge `cfg_delay`+1 edges later. The remaining words follow on consecutive edges.
- R3: Each window moves exactly `cfg_count` words. A count of zero moves none.
- R4: `cfg_width` gives the bus width in bits (8, or 10 to 16). Bits at positions at or above that width are zero in received and in driven words.
- R5: In capture mode (`cfg_mode` = 01), `fs_oe` = 011. Line 1 is high for the first `cfg_hwid` of every `cfg_hper` port clocks. Line 2 is high for the first `cfg_vwid` lines of every `cfg_vper`-line frame. Each generated line start opens a receive window under R2 and R3.
- R6: In transmit mode (`cfg_mode` = 10 or 11), `pd_oe` is high and `fs_oe` follows `cfg_nsync` (2 gives 011, 3 gives 111, any other value gives 001). Line 3 is high during line 1's high time in the first line of each frame. `pd_out` takes the next transmit-stream word at each window beat, or zero when none is waiting.
- R7: The port is half-duplex. `pd_oe` is low outside transmit mode. `fs_oe` is 000 in receive-slave mode. Nothing enters the receive stream in transmit mode.
- R8: Received words appear on the `rx_*` stream in arrival order. When the receive FIFO (8 words by default) is full, further words are dropped and `ovf` goes high, staying high until reset.
- R9: After `cfg_en` falls, `pd_oe` and `fs_oe` are low by the third port-clock edge, and no further words are received.
- R10: In reset, `rx_valid`, `pd_oe`, `fs_oe`, `fs_out` and `ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| pclk | input | 1 | Port clock |
| cfg_en | input | 1 | Port enable; falling aborts the window |
| cfg_mode | input | 2 | 00 receive slave, 01 capture, 1x transmit |
| cfg_width | input | 5 | Data width in bits |
| cfg_delay | input | CW | Edges between line start and first word |
| cfg_count | input | CW | Words per window |
| cfg_nsync | input | 2 | Number of driven syncs in transmit mode |
| cfg_hper | input | TW | Line length in port clocks |
| cfg_hwid | input | TW | Horizontal sync high time |
| cfg_vper | input | TW | Frame length in lines |
| cfg_vwid | input | TW | Vertical sync high time in lines |
| fs_in | input | 3 | Incoming frame syncs |
| fs_out | output | 3 | Generated frame syncs |
| fs_oe | output | 3 | Per-line sync output enables |
| pd_in | input | DW | Incoming port data |
| pd_out | output | DW | Driven port data |
| pd_oe | output | 1 | Data bus output enable |
| rx_data | output | DW | Received word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer accepts received word |
| tx_data | input | DW | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit FIFO has room |
| ovf | output | 1 | Sticky receive overflow |

## Verification
The incoming data bus carries a value unique to each port-clock edge. Each captured word therefore names the edge that sampled it, which separates an off-by-one delay or count from correct behaviour. Receive windows are tried with zero and non-zero delays, three widths, a zero count, and a second sync pulse inside an open window that must not restart it. Generated sync shapes are measured as high-time totals over whole frames, so a wrong period, width or line count each gives a distinct total. Transmit runs check the beat timing, the zero word driven when the transmit FIFO is empty, and the abort latency. A stalled consumer separates the correct drop-and-flag overflow behaviour from overwriting stored words.

// File: rtl/psp_afifo.sv
module psp_afifo #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wb, wg, rb, rg, wq1, wq2, rq1, rq2;

  wire wen = push && !full;
  wire ren = pop && !empty;
  wire [AW:0] wb_n = wb + (AW+1)'(wen);
  wire [AW:0] rb_n = rb + (AW+1)'(ren);
  wire [AW:0] wg_n = (wb_n >> 1) ^ wb_n;
  wire [AW:0] rg_n = (rb_n >> 1) ^ rb_n;

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wb <= '0; wg <= '0; rq1 <= '0; rq2 <= '0; full <= 1'b0;
    end else begin
      wb <= wb_n; wg <= wg_n;
      rq1 <= rg; rq2 <= rq1;
      full <= (wg_n == {~rq2[AW:AW-1], rq2[AW-2:0]});
    end

  always_ff @(posedge wclk)
    if (wen) mem[wb[AW-1:0]] <= wdata;

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rb <= '0; rg <= '0; wq1 <= '0; wq2 <= '0; empty <= 1'b1;
    end else begin
      rb <= rb_n; rg <= rg_n;
      wq1 <= wg; wq2 <= wq1;
      empty <= (rg_n == wq2);
    end

  assign rdata = mem[rb[AW-1:0]];
endmodule

// File: rtl/par_sync_port.sv
module par_sync_port #(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int CW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pclk,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_mode,
  input  logic [4:0]    cfg_width,
  input  logic [CW-1:0] cfg_delay,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_nsync,
  input  logic [TW-1:0] cfg_hper,
  input  logic [TW-1:0] cfg_hwid,
  input  logic [TW-1:0] cfg_vper,
  input  logic [TW-1:0] cfg_vwid,
  input  logic [2:0]    fs_in,
  output logic [2:0]    fs_out,
  output logic [2:0]    fs_oe,
  input  logic [DW-1:0] pd_in,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          ovf
);
  localparam logic [1:0] S_IDLE = 2'd0, S_ARM = 2'd1, S_XFER = 2'd2;

  logic [1:0]    st, en_q, ovf_q;
  logic [TW-1:0] hcnt, vcnt;
  logic [CW-1:0] dcnt, ncnt;
  logic          fs1_q, ovf_p;
  logic [DW-1:0] wmask, tx_q;
  logic          rx_full, rx_empty, tx_full, tx_empty;

  wire en_s    = en_q[1];
  wire m_in    = cfg_mode == 2'b00;
  wire m_cap   = cfg_mode == 2'b01;
  wire m_out   = cfg_mode[1];
  wire running = st != S_IDLE;
  wire trig    = m_in ? (fs_in[0] && !fs1_q) : (hcnt == '0);
  wire beat    = en_s && st == S_XFER && dcnt == '0;
  wire rx_push = beat && !m_out;
  wire tx_pop  = beat && m_out && !tx_empty;

  always_comb
    for (int i = 0; i < DW; i++) wmask[i] = i < int'(cfg_width);

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n) begin
      en_q <= '0; fs1_q <= 1'b0; st <= S_IDLE;
      hcnt <= '0; vcnt <= '0; dcnt <= '0; ncnt <= '0;
      pd_out <= '0; ovf_p <= 1'b0;
    end else begin
      en_q  <= {en_q[0], cfg_en};
      fs1_q <= fs_in[0];
      ovf_p <= ovf_p | (rx_push && rx_full);
      if (!en_s) begin
        st <= S_IDLE; hcnt <= '0; vcnt <= '0; pd_out <= '0;
      end else if (st == S_IDLE) begin
        st <= S_ARM; hcnt <= '0; vcnt <= '0;
      end else begin
        if (hcnt >= cfg_hper - TW'(1)) begin
          hcnt <= '0;
          vcnt <= (vcnt >= cfg_vper - TW'(1)) ? '0 : vcnt + TW'(1);
        end else hcnt <= hcnt + TW'(1);
        if (st == S_ARM) begin
          if (trig && cfg_count != '0) begin
            st <= S_XFER; dcnt <= cfg_delay; ncnt <= cfg_count;
          end
        end else if (dcnt != '0) dcnt <= dcnt - CW'(1);
        else begin
          ncnt <= ncnt - CW'(1);
          if (ncnt == CW'(1)) st <= S_ARM;
          if (m_out) pd_out <= tx_empty ? '0 : (tx_q & wmask);
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovf_q <= '0;
    else ovf_q <= {ovf_q[0], ovf_p};

  wire fs1g = hcnt < cfg_hwid;
  wire fs2g = vcnt < cfg_vwid;
  wire fs3g = vcnt == '0 && fs1g;

  always_comb begin
    if (!running || m_in) fs_oe = 3'b000;
    else if (m_cap || cfg_nsync == 2'd2) fs_oe = 3'b011;
    else if (cfg_nsync == 2'd3) fs_oe = 3'b111;
    else fs_oe = 3'b001;
  end

  assign fs_out   = {fs3g, fs2g, fs1g} & fs_oe;
  assign pd_oe    = running && m_out;
  assign ovf      = ovf_q[1];
  assign rx_valid = !rx_empty;
  assign tx_ready = !tx_full;

  psp_afifo #(.DW(DW), .AW(AW)) u_rxq (
    .wclk(pclk), .wrst_n(rst_n), .push(rx_push), .wdata(pd_in & wmask), .full(rx_full),
    .rclk(clk), .rrst_n(rst_n), .pop(rx_valid && rx_ready), .rdata(rx_data), .empty(rx_empty)
  );

  psp_afifo #(.DW(DW), .AW(AW)) u_txq (
    .wclk(clk), .wrst_n(rst_n), .push(tx_valid && tx_ready), .wdata(tx_data), .full(tx_full),
    .rclk(pclk), .rrst_n(rst_n), .pop(tx_pop), .rdata(tx_q), .empty(tx_empty)
  );
endmodule

// File: rtl/par_sync_port_chk.sv
module par_sync_port_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          pclk,
  input logic          rst_n,
  input logic [1:0]    cfg_mode,
  input logic [4:0]    cfg_width,
  input logic          pd_oe,
  input logic [2:0]    fs_oe,
  input logic          rx_push,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic          ovf
);
  p_halfdup_r7: assert property (@(posedge pclk) disable iff (!rst_n) pd_oe |-> !rx_push);
  p_pdoe_mode_r7: assert property (@(posedge pclk) disable iff (!rst_n) pd_oe |-> cfg_mode[1]);
  p_fsoe_slave_r7: assert property (@(posedge pclk) disable iff (!rst_n)
    (cfg_mode == 2'b00) |-> (fs_oe == 3'b000));
  p_fsoe_shape_r6: assert property (@(posedge pclk) disable iff (!rst_n)
    (fs_oe[2] |-> fs_oe[1]) and (fs_oe[1] |-> fs_oe[0]));
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_width >= 5'd8 && cfg_width < 5'd16) |-> ((rx_data >> cfg_width) == '0));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf);
endmodule

bind par_sync_port par_sync_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .pclk(pclk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
  .pd_oe(pd_oe), .fs_oe(fs_oe), .rx_push(rx_push), .rx_valid(rx_valid),
  .rx_data(rx_data), .ovf(ovf)
);

// File: tb/tb_par_sync_port.sv
module tb_par_sync_port;
  logic clk = 0, pclk = 0, rst_n = 0;
  logic cfg_en = 0;
  logic [1:0] cfg_mode = 0, cfg_nsync = 0;
  logic [4:0] cfg_width = 16;
  logic [15:0] cfg_delay = 0, cfg_count = 0, cfg_hper = 10, cfg_hwid = 1, cfg_vper = 2, cfg_vwid = 1;
  logic [2:0] fs_in = 0, fs_out, fs_oe;
  logic [15:0] pd_in = 0, pd_out, rx_data, tx_data = 0;
  logic pd_oe, rx_valid, rx_ready = 1, tx_valid = 0, tx_ready, ovf;

  int checks = 0, failures = 0, ecnt = 0, ngot = 0;
  logic [15:0] got [0:63];

  par_sync_port dut (.*);

  always #10 clk = ~clk;
  always #40 pclk = ~pclk;

  function automatic logic [15:0] pat(int n);
    return 16'(n * 16'h1357) ^ 16'hA5C3;
  endfunction
  function automatic logic [15:0] msk(int w);
    return (w >= 16) ? 16'hFFFF : 16'((1 << w) - 1);
  endfunction

  always @(posedge pclk) ecnt <= ecnt + 1;
  always @(negedge pclk) pd_in <= pat(ecnt + 1);
  always @(negedge clk)
    if (rx_valid && rx_ready && ngot < 64) begin got[ngot] = rx_data; ngot++; end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pwait(int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic t_reset();
    check("R10 rx_valid", rx_valid, 0);
    check("R10 pd_oe", pd_oe, 0);
    check("R10 fs_oe", fs_oe, 0);
    check("R10 fs_out", fs_out, 0);
    check("R10 ovf", ovf, 0);
  endtask

  task automatic t_input(int w, int d, int n, bit ghost);
    int k;
    @(negedge pclk);
    cfg_mode = 0; cfg_width = 5'(w); cfg_delay = 16'(d); cfg_count = 16'(n); cfg_en = 1;
    pwait(5);
    check("R7 slave fs_oe", fs_oe, 0);
    check("R7 slave pd_oe", pd_oe, 0);
    ngot = 0;
    fs_in[0] = 1; k = ecnt + 1;
    pwait(2); fs_in[0] = 0;
    if (ghost) begin pwait(1); fs_in[0] = 1; pwait(1); fs_in[0] = 0; end
    pwait(d + n + 12);
    check("R3 R1 word count", ngot, n);
    for (int i = 0; i < n && i < 64; i++)
      check("R2 R4 word", got[i], pat(k + 1 + d + i) & msk(w));
    cfg_en = 0; pwait(6);
  endtask

  task automatic t_capture();
    int k = -1, h1 = 0, h2 = 0, j0 = 0;
    @(negedge pclk);
    cfg_mode = 1; cfg_width = 10; cfg_delay = 2; cfg_count = 3;
    cfg_hper = 10; cfg_hwid = 3; cfg_vper = 4; cfg_vwid = 1;
    ngot = 0; cfg_en = 1;
    for (int j = 0; j < 60; j++) begin
      @(negedge pclk);
      if (k < 0 && fs_out[0]) begin k = ecnt + 1; j0 = j; end
      if (k >= 0 && j < j0 + 40) begin h1 += int'(fs_out[0]); h2 += int'(fs_out[1]); end
      if (j == 10) begin
        check("R5 capture fs_oe", fs_oe, 3'b011);
        check("R7 capture pd_oe", pd_oe, 0);
      end
    end
    check("R5 hsync high time", h1, 12);
    check("R5 vsync high time", h2, 10);
    for (int i = 0; i < 3; i++)
      check("R5 R4 capture word", got[i], pat(k + 3 + i) & msk(10));
    check("R5 second line word", got[3], pat(k + 13) & msk(10));
    cfg_en = 0; pwait(10);
  endtask

  task automatic t_output();
    logic [15:0] w [4] = '{16'h1111, 16'hBEEF, 16'h0F0F, 16'h8001};
    int k = -1, h3 = 0;
    @(negedge pclk);
    cfg_mode = 2; cfg_nsync = 3; cfg_width = 16; cfg_delay = 1; cfg_count = 4;
    cfg_hper = 12; cfg_hwid = 2; cfg_vper = 2; cfg_vwid = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); tx_valid = 1; tx_data = w[i];
    end
    @(negedge clk); tx_valid = 0;
    pwait(5);
    ngot = 0; cfg_en = 1;
    for (int j = 0; j < 40; j++) begin
      @(negedge pclk);
      if (k < 0 && fs_out[0]) k = ecnt + 1;
      if (k >= 0 && ecnt < k - 1 + 24) h3 += int'(fs_out[2]);
      if (k >= 0) begin
        for (int i = 0; i < 4; i++)
          if (ecnt == k + 2 + i) check("R6 driven word", pd_out, w[i]);
        if (ecnt == k + 14) check("R6 empty drives zero", pd_out, 0);
      end
      if (j == 10) begin
        check("R6 fs_oe nsync3", fs_oe, 3'b111);
        check("R6 pd_oe", pd_oe, 1);
      end
    end
    check("R6 line3 high time", h3, 2);
    check("R7 no rx in transmit", ngot, 0);
    cfg_en = 0;
    pwait(3);
    check("R9 abort pd_oe", pd_oe, 0);
    check("R9 abort fs_oe", fs_oe, 0);
    pwait(3);
    cfg_nsync = 1; cfg_en = 1; pwait(6);
    check("R6 fs_oe nsync1", fs_oe, 3'b001);
    cfg_en = 0; pwait(6);
  endtask

  task automatic t_abort_rx();
    int n0;
    @(negedge pclk);
    cfg_mode = 0; cfg_width = 16; cfg_delay = 0; cfg_count = 40; cfg_en = 1;
    pwait(5); ngot = 0;
    fs_in[0] = 1; pwait(2); fs_in[0] = 0;
    pwait(4); cfg_en = 0; pwait(8);
    n0 = ngot;
    pwait(20);
    check("R9 no words after abort", ngot, n0);
    check("R9 window cut short", int'(n0 < 40), 1);
  endtask

  task automatic t_overflow();
    int k;
    @(negedge pclk);
    rx_ready = 0;
    cfg_mode = 0; cfg_width = 16; cfg_delay = 0; cfg_count = 12; cfg_en = 1;
    pwait(5); ngot = 0;
    fs_in[0] = 1; k = ecnt + 1; pwait(2); fs_in[0] = 0;
    pwait(20);
    check("R8 ovf set", ovf, 1);
    cfg_en = 0; pwait(4);
    @(negedge clk); rx_ready = 1;
    pwait(6);
    check("R8 kept words", ngot, 8);
    for (int i = 0; i < 8; i++) check("R8 order", got[i], pat(k + 1 + i));
    check("R8 ovf sticky", ovf, 1);
    @(negedge pclk); rst_n = 0; pwait(2);
    check("R8 R10 ovf cleared", ovf, 0);
    rst_n = 1; pwait(2);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pwait(3);
    t_reset();
    @(negedge pclk); rst_n = 1;
    pwait(3);
    t_input(16, 0, 4, 0);
    t_input(8, 5, 3, 0);
    t_input(12, 0, 6, 1);
    t_input(16, 2, 0, 0);
    t_capture();
    t_output();
    t_abort_rx();
    t_overflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule